// File: doc/BRIEF.md
# Configurable Pixel Channel Extractor

This block sits in a display path after the pixel fetch stage. It receives packed pixel words of one to four bytes on a 32-bit valid/ready stream. For each word it pulls out the red, green and blue components at bit positions and widths that software chooses at run time. Each component is then widened or narrowed to 8 bits, so a downstream encoder always sees 8:8:8 RGB with a valid flag.

Software sets the pixel width and the three channel selections through a simple register write port. Each pixel takes a snapshot of the settings at the moment it is accepted and carries it through the pipeline. A register write therefore never changes a pixel that is already in flight. The pipeline has two register stages and no stalls. Once reset is released the input is always ready.

Top module: `pix_chan_extract`

## Requirements
- R1: The format register (address 0) holds the bytes per pixel minus one in bits [4:3], so 0 means 8-bit, 1 means 16-bit, 2 means 24-bit and 3 means 32-bit. Input bytes above the configured width are forced to zero before any channel is extracted.
- R2: Red, green and blue selections live at addresses 1, 2 and 3. Each holds the bit offset in bits [4:0] and the length in bits [11:8]. The red register also keeps a default colour from bits [23:16]. After reset the block decodes 32-bit pixels with red at offset 0, green at 8 and blue at 16, each 8 bits long, and the red default is 0. A write changes only the register it addresses.
- R3: A channel's raw field is the `len` bits of the masked pixel that start at bit `off`. Bits above 31 read as zero.
- R4: A field of 1 to 7 bits is widened to 8 bits by repeating its bit pattern from the most significant bit downward. For example, 5-bit `f` becomes `{f, f[4:2]}`.
- R5: A field of 8 to 15 bits is reduced to its 8 most significant bits.
- R6: A length of 0 outputs the red default colour on the red channel and 0 on green or blue.
- R7: A pixel accepted at one rising edge appears on the RGB outputs with `out_valid` high after the second rising edge that follows. `out_valid` is low in every cycle that has no such pixel.
- R8: A pixel uses the register values that were in place at its acceptance edge. A write made at that edge, or at any later edge, affects only later pixels.
- R9: While `rst_n` is low, `in_ready` and `out_valid` are 0 and the RGB outputs are 0.
- R10: `in_ready` is 1 in every cycle after the first rising edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel |
| in_pixel | input | 32 | Packed pixel word, byte 0 in bits [7:0] |
| out_valid | output | 1 | RGB outputs hold a pixel |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
A wrong offset, length or byte mask shows up as a wrong colour value on the very pixel that uses it, two edges after acceptance. Mixing 16-, 24- and 32-bit layouts with random selections exposes such errors within a few pixels. A broken snapshot shows up only when a write lands while a pixel is in flight. The bench therefore issues writes in the same cycle as pixels and checks that the pixel uses the older setting. A latency or valid-flag fault makes every comparison after the first accepted pixel disagree.

// File: rtl/pce_pkg.sv
// Package: shared widths and types for the pixel channel extractor.
// Assumes a 32-bit pixel word with up to four bytes.
package pce_pkg;
    localparam int PIX_W  = 32;
    localparam int NBYTES = PIX_W / 8;
    localparam int OFF_W  = $clog2(PIX_W);
    localparam int LEN_W  = 4;
    localparam int CH_W   = 8;
    localparam int FMT_W  = $clog2(NBYTES);
    localparam int NCH    = 3;

    // Register addresses; the bench and software rely on these values.
    typedef enum logic [1:0] {
        A_FMT = 2'd0,
        A_RED = 2'd1,
        A_GRN = 2'd2,
        A_BLU = 2'd3
    } cfg_addr_e;

    // One channel selection: bit offset, field length, default colour.
    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] len;
        logic [CH_W-1:0]  dflt;
    } chan_sel_t;
endpackage

// File: rtl/pce_cfg_regs.sv
// Register file for format and channel selections.
// Assumes single-cycle writes; only red keeps a default colour.
module pce_cfg_regs
    import pce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [31:0]           wr_data,
    output logic [FMT_W-1:0]      fmt_o,
    output chan_sel_t [NCH-1:0]   sel_o
);
    localparam logic [FMT_W-1:0] FMT_RST = FMT_W'(NBYTES - 1);

    // Format register: bytes-per-pixel minus one from bits [4:3].
    always_ff @(posedge clk) begin
        if (!rst_n)
            fmt_o <= FMT_RST;
        else if (wr_en && wr_addr == A_FMT)
            fmt_o <= wr_data[3 +: FMT_W];
    end

    // One selection register per channel; index 0 red, 1 green, 2 blue.
    for (genvar c = 0; c < NCH; c++) begin : g_sel
        localparam logic [1:0] MY_ADDR = 2'(c + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_o[c].off  <= OFF_W'(8 * c);
                sel_o[c].len  <= LEN_W'(8);
                sel_o[c].dflt <= '0;
            end else if (wr_en && wr_addr == MY_ADDR) begin
                sel_o[c].off  <= wr_data[OFF_W-1:0];
                sel_o[c].len  <= wr_data[8 +: LEN_W];
                sel_o[c].dflt <= (c == 0) ? wr_data[16 +: CH_W] : '0;
            end
        end
    end

    // R2
    grn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_GRN) |=> $stable(sel_o[1]));
endmodule

// File: rtl/pce_byte_mask.sv
// Clears pixel bytes above the configured width.
// Assumes fmt holds bytes-per-pixel minus one.
module pce_byte_mask
    import pce_pkg::*;
(
    input  logic [PIX_W-1:0] pix_i,
    input  logic [FMT_W-1:0] fmt_i,
    output logic [PIX_W-1:0] pix_o
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Keep a byte only when its index is within the pixel width.
        assign pix_o[8*b +: 8] = (FMT_W'(b) <= fmt_i) ? pix_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_chan_unit.sv
// Extracts one colour field and scales it to CH_W bits.
// Short fields repeat their pattern from the MSB down; long fields keep
// their top bits; a zero length gives the channel default.
module pce_chan_unit
    import pce_pkg::*;
(
    input  logic [PIX_W-1:0] pix_i,
    input  chan_sel_t        sel_i,
    output logic [CH_W-1:0]  val_o
);
    localparam int FLD_W = 1 << LEN_W;

    logic [FLD_W-1:0] fld;
    logic [PIX_W-1:0] shifted;

    // Shift the field down to bit 0 and clear everything above its length.
    always_comb begin
        shifted = pix_i >> sel_i.off;
        fld     = FLD_W'(shifted) & ((FLD_W'(1) << sel_i.len) - FLD_W'(1));
    end

    // Map each output bit onto a field bit, wrapping over short fields.
    always_comb begin
        int l;
        int pos;
        l     = int'(sel_i.len);
        pos   = 0;
        val_o = '0;
        if (l == 0) begin
            val_o = sel_i.dflt;
        end else begin
            for (int i = 0; i < CH_W; i++) begin
                pos      = l - 1 - ((CH_W - 1 - i) % l);
                val_o[i] = fld[pos[LEN_W-1:0]];
            end
        end
    end
endmodule

// File: rtl/pix_chan_extract.sv
// Top: two-stage pixel channel extractor.
// Stage 1 captures the masked pixel and a snapshot of the selections at
// acceptance; stage 2 extracts and scales the three channels.
// Assumes no output backpressure, so the input is ready out of reset.
module pix_chan_extract
    import pce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_pixel,
    output logic        out_valid,
    output logic [7:0]  out_r,
    output logic [7:0]  out_g,
    output logic [7:0]  out_b
);
    logic [FMT_W-1:0]    fmt;
    chan_sel_t [NCH-1:0] sel;
    logic [PIX_W-1:0]    masked;
    logic                accept;

    logic                s1_valid;
    logic [PIX_W-1:0]    s1_pix;
    chan_sel_t [NCH-1:0] s1_sel;
    logic [CH_W-1:0]     ch_val [NCH];

    pce_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .fmt_o   (fmt),
        .sel_o   (sel)
    );

    pce_byte_mask u_mask (
        .pix_i (in_pixel),
        .fmt_i (fmt),
        .pix_o (masked)
    );

    assign accept = in_valid && in_ready;

    // Ready goes high on the first edge out of reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Stage 1: capture the masked pixel and its selection snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pix   <= '0;
            s1_sel   <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_pix <= masked;
                s1_sel <= sel;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pce_chan_unit u_ch (
            .pix_i (s1_pix),
            .sel_i (s1_sel[c]),
            .val_o (ch_val[c])
        );
    end

    // Stage 2: register the scaled channels and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_r     <= '0;
            out_g     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_r <= ch_val[0];
                out_g <= ch_val[1];
                out_b <= ch_val[2];
            end
        end
    end

    // R7
    lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid);
    // R7
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ##1 !out_valid);
    // R6
    grn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_valid) && $past(s1_sel[1].len) == '0) |-> out_g == 8'h00);
    // R10
    ready_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

// File: tb/pix_chan_extract_bench.sv
module pix_chan_extract_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    // Bench copy of the register state, per requirement R2.
    logic [1:0] m_fmt;
    logic [4:0] m_off [3];
    logic [3:0] m_len [3];
    logic [7:0] m_dflt;

    // Two-deep expectation pipeline.
    bit          d1_v, d2_v;
    logic [23:0] d1_rgb, d2_rgb;
    string       d1_tag, d2_tag;

    always #4 clk = ~clk;

    pix_chan_extract u_pix_chan_extract (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_r(out_r),
        .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_chan(logic [31:0] px, int ch);
        logic [31:0] m;
        logic [31:0] fld;
        logic [31:0] rep;
        int l, tot;
        m = px;
        for (int b = 0; b < 4; b++) if (b > int'(m_fmt)) m[8*b +: 8] = 8'h00;
        l   = int'(m_len[ch]);
        fld = (m >> m_off[ch]) & ((32'd1 << l) - 32'd1);
        if (l == 0) return (ch == 0) ? m_dflt : 8'h00;
        if (l >= 8) return 8'(fld >> (l - 8));
        rep = 0;
        tot = 0;
        while (tot < 8) begin
            rep = (rep << l) | fld;
            tot += l;
        end
        return 8'(rep >> (tot - 8));
    endfunction

    task automatic model_write(logic [1:0] a, logic [31:0] d);
        if (a == 2'd0) m_fmt = d[4:3];
        else begin
            m_off[a-1] = d[4:0];
            m_len[a-1] = d[11:8];
            if (a == 2'd1) m_dflt = d[23:16];
        end
    endtask

    // One cycle: check outputs, shift expectations, drive the next inputs.
    task automatic step(bit v, logic [31:0] px, bit we, logic [1:0] a, logic [31:0] d, string tag);
        if (d2_v) begin
            chk(out_valid === 1'b1, {"R7 ", d2_tag}, "out_valid", 32'(out_valid), 1);
            chk(out_r === d2_rgb[23:16], d2_tag, "red", 32'(out_r), 32'(d2_rgb[23:16]));
            chk(out_g === d2_rgb[15:8],  d2_tag, "green", 32'(out_g), 32'(d2_rgb[15:8]));
            chk(out_b === d2_rgb[7:0],   d2_tag, "blue", 32'(out_b), 32'(d2_rgb[7:0]));
        end else begin
            chk(out_valid === 1'b0, "R7", "idle out_valid", 32'(out_valid), 0);
        end
        d2_v = d1_v; d2_rgb = d1_rgb; d2_tag = d1_tag;
        d1_v = v;
        d1_rgb = {exp_chan(px, 0), exp_chan(px, 1), exp_chan(px, 2)};
        d1_tag = tag;
        in_valid = v; in_pixel = px;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        if (we) model_write(a, d);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        step(1'b0, 32'h0, 1'b1, a, d, "cfg");
    endtask

    function automatic logic [31:0] selw(int off, int len, int dflt);
        return (32'(dflt) << 16) | (32'(len) << 8) | 32'(off);
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        m_fmt = 2'd3;
        m_off[0] = 5'd0; m_off[1] = 5'd8; m_off[2] = 5'd16;
        m_len[0] = 4'd8; m_len[1] = 4'd8; m_len[2] = 4'd8;
        m_dflt = 8'h00;
        d1_v = 0; d2_v = 0; d1_rgb = 0; d2_rgb = 0; d1_tag = ""; d2_tag = "";

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(in_ready === 1'b0, "R9", "in_ready in reset", 32'(in_ready), 0);
        chk(out_valid === 1'b0, "R9", "out_valid in reset", 32'(out_valid), 0);
        chk({out_r, out_g, out_b} === 24'h0, "R9", "rgb in reset", 32'({out_r, out_g, out_b}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: ready after reset
        chk(in_ready === 1'b1, "R10", "in_ready after reset", 32'(in_ready), 1);

        // R2: reset layout is 32-bit, red 0, green 8, blue 16; alpha ignored
        step(1, 32'hAA33_2211, 0, 0, 0, "R2 R1");
        step(1, 32'h00FF_80C0, 0, 0, 0, "R2");
        // R1 R4: 16-bit 5:6:5
        wr(2'd0, 32'h08);
        wr(2'd1, selw(11, 5, 0));
        wr(2'd2, selw(5, 6, 0));
        wr(2'd3, selw(0, 5, 0));
        step(1, 32'hFFFF_F800, 0, 0, 0, "R1 R4");
        step(1, 32'h1234_07E0, 0, 0, 0, "R1 R4");
        step(1, 32'h5555_A5C3, 0, 0, 0, "R1 R3 R4");
        // R1: 24-bit, blue 0, green 8, red 16; top byte masked
        wr(2'd0, 32'h10);
        wr(2'd1, selw(16, 8, 0));
        wr(2'd2, selw(8, 8, 0));
        wr(2'd3, selw(0, 8, 0));
        step(1, 32'hFF12_3456, 0, 0, 0, "R1 R3");
        // R1: 8-bit width masks bits above 7
        wr(2'd0, 32'h00);
        wr(2'd1, selw(4, 8, 0));
        step(1, 32'hABCD_EF5A, 0, 0, 0, "R1");
        // R6: zero lengths
        wr(2'd0, 32'h18);
        wr(2'd1, selw(3, 0, 8'h9C));
        wr(2'd2, selw(0, 0, 8'h77));
        step(1, 32'hFFFF_FFFF, 0, 0, 0, "R6");
        // R5: 15-bit and 9-bit fields
        wr(2'd1, selw(17, 15, 0));
        wr(2'd2, selw(3, 9, 0));
        wr(2'd3, selw(31, 1, 0));
        step(1, 32'hC0FE_1234, 0, 0, 0, "R5 R3 R4");
        step(1, 32'h7FFF_0000, 0, 0, 0, "R5 R3");
        // R8: write in the acceptance cycle and while in flight
        step(1, 32'h0F0F_F0F0, 1, 2'd1, selw(4, 3, 0), "R8");
        step(1, 32'h0F0F_F0F0, 1, 2'd1, selw(0, 8, 0), "R8");
        step(1, 32'h0F0F_F0F0, 0, 0, 0, "R8");
        // Idle gap
        step(0, 32'h0, 0, 0, 0, "R7");
        step(0, 32'h0, 0, 0, 0, "R7");

        // Random traffic with interleaved register writes.
        for (int n = 0; n < 600; n++) begin
            bit v;
            bit we;
            v  = ($urandom % 4) != 0;
            we = ($urandom % 5) == 0;
            step(v, $urandom, we, 2'($urandom), $urandom, "R3 R4 R5 R8");
        end
        step(0, 32'h0, 0, 0, 0, "R7");
        step(0, 32'h0, 0, 0, 0, "R7");
        step(0, 32'h0, 0, 0, 0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule